// File: doc/BRIEF.md
# Windowed Register File with Overlapping Parameter Sets

This block is a register file that gives every procedure a 32-entry logical register view while holding 74 physical registers. Ten global registers are seen by all procedures. The rest of the storage is arranged as four windows on a ring. Each window owns ten private registers and shares a group of six registers with the window on either side. A caller writes its arguments into its outgoing group. After a call, the callee sees the same physical registers as its incoming group, so no registers are copied.

The block has two combinational read ports and one write port, all addressed by 5-bit logical register numbers. A call pulse moves the current window forward by one and a return pulse moves it back by one, both with wraparound. The window in use is visible on an output so that surrounding control can follow it. Spilling windows to memory on overflow is left to that surrounding control.

Top module: `regwin_file`

## Requirements
- R1: After reset the current window is 0 (window index encoding 0..3 on `win_o`) and every logical register reads as zero in every window.
- R2: Logical registers 0 to 9 address physical registers 0 to 9 in every window, so a value written there is read back unchanged after any number of calls and returns.
- R3: In window w, logical 10..15 address physical 10+16w..15+16w (incoming group), logical 16..25 address physical 16+16w..25+16w (private group), and logical 26..31 address the incoming group of window (w+1) mod 4.
- R4: A value written to logical 26+k in window w is read at logical 10+k in window (w+1) mod 4. This includes window 3 handing over to window 0.
- R5: Private registers (logical 16..25) of a window keep their values while the other windows write their own private and outgoing registers.
- R6: A call pulse alone, sampled at a rising edge, makes `win_o` become (w+1) mod 4 after that edge.
- R7: A return pulse alone makes `win_o` become (w+3) mod 4 after the edge.
- R8: Call and return asserted in the same cycle leave the window unchanged.
- R9: Reads are combinational. A write with `wr_en` high takes effect at the rising edge, so a read of the same register in the write cycle shows the old value and the new value appears after the edge.
- R10: A write in the same cycle as a call or return is translated with the window in effect before that edge.
- R11: With `wr_en` low, `wr_addr` and `wr_data` change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_addr | input | 5 | Logical register number, read port A |
| rd_a_data | output | 32 | Data of read port A |
| rd_b_addr | input | 5 | Logical register number, read port B |
| rd_b_data | output | 32 | Data of read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical register number to write |
| wr_data | input | 32 | Write data |
| call_i | input | 1 | Call pulse: advance the window |
| ret_i | input | 1 | Return pulse: move the window back |
| win_o | output | 2 | Current window index |

## Verification
A register write and a window move can fall on the same clock edge. In that case the write address must be translated through the window that is current before the edge. The bench provokes this by writing a private register in the same cycle as a call. It then reads that logical number in the new window, where it must be unaffected, and again after a return, where the written value must appear. Call and return in one cycle are also driven together, and the window must hold.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Physical index of logical register lreg seen from window win.
  function automatic int phys_of(input int win, input int lreg, input int globals,
                                 input int shared, input int locals, input int windows);
    int stride;
    stride = shared + locals;
    if (lreg < globals) return lreg;
    if (lreg < globals + shared + locals) return globals + win * stride + (lreg - globals);
    return globals + ((win + 1) % windows) * stride + (lreg - globals - shared - locals);
  endfunction

  // Window index moved by delta steps around the ring.
  function automatic int win_step(input int win, input int delta, input int windows);
    return (win + delta + windows) % windows;
  endfunction

endpackage

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int WINDOWS = 4,
  parameter int WIN_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [WIN_W-1:0] win_q
);
  import regwin_pkg::*;

  logic [WIN_W-1:0] win_nxt;

  always_comb begin
    unique case ({call_i, ret_i})
      2'b10:   win_nxt = WIN_W'(win_step(int'(win_q), 1, WINDOWS));
      2'b01:   win_nxt = WIN_W'(win_step(int'(win_q), -1, WINDOWS));
      default: win_nxt = win_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_nxt;
  end
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate #(
  parameter int GLOBALS = 10,
  parameter int SHARED  = 6,
  parameter int LOCALS  = 10,
  parameter int WINDOWS = 4,
  parameter int LOG_W   = 5,
  parameter int PHYS_W  = 7,
  parameter int WIN_W   = 2
) (
  input  logic [WIN_W-1:0]  win,
  input  logic [LOG_W-1:0]  lreg,
  output logic [PHYS_W-1:0] phys
);
  import regwin_pkg::*;

  always_comb begin
    phys = PHYS_W'(phys_of(int'(win), int'(lreg), GLOBALS, SHARED, LOCALS, WINDOWS));
  end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
  parameter int PHYS_REGS = 74,
  parameter int PHYS_W    = 7,
  parameter int DATA_W    = 32,
  parameter int RD_PORTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [PHYS_W-1:0] wr_phys,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PHYS_W-1:0] rd_phys [RD_PORTS],
  output logic [DATA_W-1:0] rd_data [RD_PORTS]
);
  logic [DATA_W-1:0] cells [PHYS_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_REGS; i++) cells[i] <= '0;
    end else if (wr_strobe && (int'(wr_phys) < PHYS_REGS)) begin
      cells[wr_phys] <= wr_data;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_data[p] = (int'(rd_phys[p]) < PHYS_REGS) ? cells[rd_phys[p]] : '0;
  end
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter  int DATA_W    = 32,
  parameter  int GLOBALS   = 10,
  parameter  int LOCALS    = 10,
  parameter  int SHARED    = 6,
  parameter  int WINDOWS   = 4,
  localparam int STRIDE    = LOCALS + SHARED,
  localparam int PHYS_REGS = GLOBALS + WINDOWS * STRIDE,
  localparam int LOG_REGS  = GLOBALS + 2 * SHARED + LOCALS,
  localparam int LOG_W     = $clog2(LOG_REGS),
  localparam int PHYS_W    = $clog2(PHYS_REGS),
  localparam int WIN_W     = $clog2(WINDOWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [LOG_W-1:0]  rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [LOG_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              call_i,
  input  logic              ret_i,
  output logic [WIN_W-1:0]  win_o
);
  localparam int XPORTS = 3;  // read A, read B, write

  // Named internal events for the checker
  logic [WIN_W-1:0]  win_q;
  logic [PHYS_W-1:0] phys_a, phys_b, phys_w;
  logic              wr_strobe;

  logic [LOG_W-1:0]  lreg_bus [XPORTS];
  logic [PHYS_W-1:0] phys_bus [XPORTS];
  logic [PHYS_W-1:0] rd_phys  [2];
  logic [DATA_W-1:0] rd_data  [2];

  regwin_ptr #(.WINDOWS(WINDOWS), .WIN_W(WIN_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .win_q(win_q)
  );

  assign lreg_bus[0] = rd_a_addr;
  assign lreg_bus[1] = rd_b_addr;
  assign lreg_bus[2] = wr_addr;

  for (genvar k = 0; k < XPORTS; k++) begin : g_xl
    regwin_xlate #(
      .GLOBALS(GLOBALS), .SHARED(SHARED), .LOCALS(LOCALS), .WINDOWS(WINDOWS),
      .LOG_W(LOG_W), .PHYS_W(PHYS_W), .WIN_W(WIN_W)
    ) u_xl (
      .win(win_q), .lreg(lreg_bus[k]), .phys(phys_bus[k])
    );
  end

  assign phys_a    = phys_bus[0];
  assign phys_b    = phys_bus[1];
  assign phys_w    = phys_bus[2];
  assign wr_strobe = wr_en;
  assign rd_phys[0] = phys_a;
  assign rd_phys[1] = phys_b;

  regwin_store #(
    .PHYS_REGS(PHYS_REGS), .PHYS_W(PHYS_W), .DATA_W(DATA_W), .RD_PORTS(2)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_phys(phys_w),
    .wr_data(wr_data), .rd_phys(rd_phys), .rd_data(rd_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign win_o     = win_q;
endmodule

// File: rtl/regwin_checker.sv
module regwin_checker #(
  parameter int WINDOWS   = 4,
  parameter int GLOBALS   = 10,
  parameter int PHYS_REGS = 74,
  parameter int WIN_W     = 2,
  parameter int LOG_W     = 5,
  parameter int PHYS_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic              ret_i,
  input logic              wr_en,
  input logic              wr_strobe,
  input logic [WIN_W-1:0]  win_q,
  input logic [LOG_W-1:0]  rd_a_addr,
  input logic [PHYS_W-1:0] phys_a,
  input logic [PHYS_W-1:0] phys_w
);
  assert_call_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_i) |=> (int'(win_q) == (int'($past(win_q)) + 1) % WINDOWS));

  assert_ret_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |=> (int'(win_q) == (int'($past(win_q)) + WINDOWS - 1) % WINDOWS));

  assert_both_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i == ret_i) |=> $stable(win_q));

  assert_global_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_a_addr) < GLOBALS) |-> (int'(phys_a) == int'(rd_a_addr)));

  assert_rd_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phys_a) < PHYS_REGS);

  assert_wr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (int'(phys_w) < PHYS_REGS));

  assert_no_stray_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !wr_strobe);
endmodule

bind regwin_file regwin_checker #(
  .WINDOWS(WINDOWS), .GLOBALS(GLOBALS), .PHYS_REGS(PHYS_REGS),
  .WIN_W(WIN_W), .LOG_W(LOG_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .wr_en(wr_en),
  .wr_strobe(wr_strobe), .win_q(win_q), .rd_a_addr(rd_a_addr),
  .phys_a(phys_a), .phys_w(phys_w)
);

// File: tb/regwin_file_test.sv
module regwin_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
  logic [1:0]  win_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state
  logic [31:0] mem [74];
  int          win = 0;

  // Scoreboard queues
  logic [31:0] q_a [$];
  logic [31:0] q_b [$];
  int          q_w [$];
  string       q_req [$];

  regwin_file uut (
    .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .call_i(call_i), .ret_i(ret_i), .win_o(win_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  // Reference mapping: offset into the 64-entry ring after the globals
  function automatic int ref_phys(input int w, input int l);
    if (l < 10) return l;
    return 10 + ((w * 16 + (l - 10)) % 64);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue what the outputs must show
  task automatic step(input int ra, input int rb, input bit we, input int wa,
                      input logic [31:0] wd, input bit c, input bit r, input string req);
    @(negedge clk);
    rd_a_addr = 5'(ra);
    rd_b_addr = 5'(rb);
    wr_en     = we;
    wr_addr   = 5'(wa);
    wr_data   = wd;
    call_i    = c;
    ret_i     = r;
    q_a.push_back(mem[ref_phys(win, ra)]);
    q_b.push_back(mem[ref_phys(win, rb)]);
    q_w.push_back(win);
    q_req.push_back(req);
    if (we) mem[ref_phys(win, wa)] = wd;
    if (c && !r) win = (win + 1) % 4;
    if (r && !c) win = (win + 3) % 4;
  endtask

  // Monitor: sample halfway between the driving edge and the active edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q_req.size() > 0) begin
        string       rq;
        logic [31:0] ea, eb;
        int          ew;
        rq = q_req.pop_front();
        ea = q_a.pop_front();
        eb = q_b.pop_front();
        ew = q_w.pop_front();
        chk(rq, "rd_a_data", rd_a_data, ea);
        chk(rq, "rd_b_data", rd_b_data, eb);
        chk(rq, "win_o", {30'd0, win_o}, 32'(ew));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic fill_window(input logic [31:0] tag, input int lo);
    for (int l = lo; l < 32; l++) step(l, 3, 1, l, tag | 32'(l), 0, 0, "R9");
  endtask

  initial begin
    for (int i = 0; i < 74; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared storage, window 0
    step(0, 31, 0, 0, 0, 0, 0, "R1");
    step(12, 22, 0, 0, 0, 0, 0, "R1");

    // R9: write every logical register in window 0; same-cycle read shows old value
    for (int l = 0; l < 32; l++) step(l, l, 1, l, 32'hA000_0000 | 32'(l), 0, 0, "R9");
    // R3: read back the whole view
    for (int l = 0; l < 32; l++) step(l, 31 - l, 0, 0, 0, 0, 0, "R3");

    // R6: call to window 1; R4: incoming group equals caller's outgoing group
    step(0, 0, 0, 0, 0, 1, 0, "R6");
    for (int l = 10; l < 16; l++) step(l, l + 16, 0, 0, 0, 0, 0, "R4");
    step(3, 9, 0, 0, 0, 0, 0, "R2");
    fill_window(32'hB000_0000, 16);

    step(0, 0, 0, 0, 0, 1, 0, "R6");
    step(4, 8, 0, 0, 0, 0, 0, "R2");
    fill_window(32'hC000_0000, 16);

    step(0, 0, 0, 0, 0, 1, 0, "R6");
    step(5, 7, 0, 0, 0, 0, 0, "R2");
    fill_window(32'hD000_0000, 16);

    // R6: wrap from window 3 to window 0; R4: window 3 outgoing lands in window 0 incoming
    step(0, 0, 0, 0, 0, 1, 0, "R6");
    for (int l = 10; l < 16; l++) step(l, l, 0, 0, 0, 0, 0, "R4");
    // R5: window 0 private registers untouched by the others
    for (int l = 16; l < 26; l++) step(l, l, 0, 0, 0, 0, 0, "R5");

    // R7: return wraps from window 0 to window 3, then back down
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    step(16, 26, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    step(20, 12, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, "R7");
    step(20, 28, 0, 0, 0, 0, 0, "R7");

    // R8: call and return together hold the window
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    step(20, 1, 0, 0, 0, 0, 0, "R8");
    step(21, 2, 0, 0, 0, 1, 1, "R8");
    step(22, 2, 0, 0, 0, 0, 0, "R8");

    // R10: write with call in the same cycle uses the old window
    step(20, 20, 1, 20, 32'hEEEE_0014, 1, 0, "R10");
    step(20, 26, 0, 0, 0, 0, 0, "R10");
    step(20, 10, 0, 0, 0, 0, 1, "R10");
    step(20, 21, 0, 0, 0, 0, 0, "R10");
    // R10: write with return in the same cycle
    step(26, 27, 1, 27, 32'h1234_5678, 0, 1, "R10");
    step(27, 11, 0, 0, 0, 1, 0, "R10");
    step(11, 27, 0, 0, 0, 0, 0, "R10");

    // R11: disabled write leaves the target intact
    step(21, 0, 0, 21, 32'hFFFF_FFFF, 0, 0, "R11");
    step(21, 0, 0, 0, 0, 0, 0, "R11");
    step(5, 30, 0, 5, 32'h0BAD_0BAD, 0, 0, "R11");
    step(5, 30, 0, 0, 0, 0, 0, "R11");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule